// File: doc/BRIEF.md
# Periodic Tick Down-Counter Timer

This block is a free-running periodic timer for a processor subsystem. A counter, 24 bits wide by default, counts down by one on each selected tick. When it steps from one to zero it sets a sticky "wrapped" flag and, if enabled, raises a one-cycle interrupt request. On the next tick after zero it reloads from a software-written reload value, so a reload value of N gives a period of N+1 ticks.

Software reaches the timer through four 32-bit word registers on a simple single-cycle bus. The select, write and word-index inputs are qualified in the same cycle, and read data is combinational from the addressed word. Word 0 holds control and status. Word 1 holds the reload value. Word 2 returns the live count, and any write to it zeroes the counter. Word 3 is a read-only calibration word whose contents are fixed by parameters.

The tick source is the processor clock itself or an external reference tick-enable input. A control bit chooses between them.

Top module: `tick_down_timer`

## Requirements
- R1: After reset, words 0, 1 and 2 read as zero and `tick_irq` is low.
- R2: Word 0 layout (word index 0):
  - bit 0 is the run enable.
  - bit 1 is the interrupt enable.
  - bit 2 is the tick source select.
  - bit 16 is the wrapped flag.
  - All other bits read as zero.
  - Writes to bit 16 and to the zero bits have no effect.
- R3: While the run enable is 0, the count holds its value.
- R4: Word 1 (index 1) holds a reload value of CNT_W bits in its low bits, and its upper bits read as zero. A tick that finds the count at zero loads the reload value, so the period is reload+1 ticks.
- R5: The wrapped flag is set by a tick that takes the count from 1 to 0. It is cleared on the edge that completes a read of word 0. When both happen on the same edge, setting wins.
- R6: When the interrupt enable is 1, `tick_irq` is high for exactly the one cycle that follows the edge on which the count reached zero. When the interrupt enable is 0, `tick_irq` stays low.
- R7: A write of any data to word 2 (index 2) does three things on that edge:
  - the count becomes 0;
  - the wrapped flag is cleared;
  - no interrupt is raised, even if a tick would have reached zero on the same edge.
- R8: With the source select at 1, the counter ticks on every clock. With the source select at 0, it ticks only on clocks where `ref_tick` is high.
- R9: With the count at 0 and the reload at 0, the count stays at 0, and neither the flag nor the interrupt is raised.
- R10: Word 3 (index 3) reads as follows, and writes to it are ignored:
  - bit 31 is CAL_NOREF;
  - bit 30 is CAL_SKEW;
  - bits 23:0 are CAL_TENMS;
  - all other bits are zero.
- R11: A read of word 2 returns the live count, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | External reference tick enable, used when the source select is 0 |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 2 | Word index (0 control, 1 reload, 2 count, 3 calibration) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| tick_irq | output | 1 | One-cycle interrupt pulse on reaching zero |

## Verification
The bench builds the timer with CNT_W = 8, CAL_NOREF = 1, CAL_SKEW = 1 and CAL_TENMS = 0x1F40. The narrow counter makes the reload truncation visible, and the nonzero calibration parameters make every calibration field observable.

Short reloads let the bench sweep every reload from 1 to 12 through two full periods. For each one it compares the count and the interrupt pin with the arithmetic model on every cycle. Further cases line up the edge-exact events: the count-clear write landing on the zero step, and a control read landing on the flag set. A sparse reference-tick pattern exercises the gated tick source.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

  typedef enum logic [1:0] {
    WIDX_CTRL    = 2'd0,
    WIDX_RELOAD  = 2'd1,
    WIDX_CURRENT = 2'd2,
    WIDX_CALIB   = 2'd3
  } widx_e;

  localparam int unsigned CTRL_RUN_POS  = 0;
  localparam int unsigned CTRL_IE_POS   = 1;
  localparam int unsigned CTRL_SRC_POS  = 2;
  localparam int unsigned CTRL_FLAG_POS = 16;

  localparam int unsigned CAL_NOREF_POS = 31;
  localparam int unsigned CAL_SKEW_POS  = 30;
  localparam int unsigned CAL_FIELD_W   = 24;

  typedef struct packed {
    logic src_core;
    logic irq_en;
    logic run;
  } ctrl_t;

  function automatic logic [31:0] pack_ctrl(ctrl_t c, logic flag);
    logic [31:0] w;
    w = '0;
    w[CTRL_RUN_POS]  = c.run;
    w[CTRL_IE_POS]   = c.irq_en;
    w[CTRL_SRC_POS]  = c.src_core;
    w[CTRL_FLAG_POS] = flag;
    return w;
  endfunction

  function automatic ctrl_t unpack_ctrl(logic [31:0] d);
    ctrl_t c;
    c.run      = d[CTRL_RUN_POS];
    c.irq_en   = d[CTRL_IE_POS];
    c.src_core = d[CTRL_SRC_POS];
    return c;
  endfunction

  function automatic logic [31:0] pack_calib(logic noref, logic skew,
                                             logic [CAL_FIELD_W-1:0] tenms);
    logic [31:0] w;
    w = '0;
    w[CAL_FIELD_W-1:0] = tenms;
    w[CAL_NOREF_POS]   = noref;
    w[CAL_SKEW_POS]    = skew;
    return w;
  endfunction

endpackage

// File: rtl/tdt_regs.sv
module tdt_regs
  import tdt_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter bit CAL_NOREF = 1'b0,
  parameter bit CAL_SKEW  = 1'b0,
  parameter logic [CAL_FIELD_W-1:0] CAL_TENMS = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_widx,
  input  logic [31:0]      bus_wdata,
  input  logic [CNT_W-1:0] count,
  input  logic             flag,
  output ctrl_t            ctrl,
  output logic [CNT_W-1:0] reload,
  output logic             wr_current,
  output logic             rd_ctrl,
  output logic [31:0]      bus_rdata
);

  localparam logic [31:0] CAL_WORD = pack_calib(CAL_NOREF, CAL_SKEW, CAL_TENMS);

  widx_e idx;
  logic  wr_ctrl;
  logic  wr_reload;

  assign idx        = widx_e'(bus_widx);
  assign wr_ctrl    = bus_sel && bus_wr && (idx == WIDX_CTRL);
  assign wr_reload  = bus_sel && bus_wr && (idx == WIDX_RELOAD);
  assign wr_current = bus_sel && bus_wr && (idx == WIDX_CURRENT);
  assign rd_ctrl    = bus_sel && !bus_wr && (idx == WIDX_CTRL);

  generate
    if (CNT_W < 32) begin : g_hi_bits
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[31:CNT_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else begin
      if (wr_ctrl)   ctrl   <= unpack_ctrl(bus_wdata);
      if (wr_reload) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (idx)
      WIDX_CTRL:    bus_rdata = pack_ctrl(ctrl, flag);
      WIDX_RELOAD:  bus_rdata = 32'(reload);
      WIDX_CURRENT: bus_rdata = 32'(count);
      default:      bus_rdata = CAL_WORD;
    endcase
  end

endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_core,
  input  logic             ref_tick,
  input  logic [CNT_W-1:0] reload,
  input  logic             clear,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             zero_evt,
  output logic             reload_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur,
                                                  logic [CNT_W-1:0] rld);
    return (cur == '0) ? rld : cur - ONE;
  endfunction

  assign tick       = run && (src_core || ref_tick);
  assign zero_evt   = tick && !clear && (count == ONE);
  assign reload_evt = tick && !clear && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (tick)   count <= next_count(count, reload);
  end

endmodule

// File: rtl/tdt_event.sv
module tdt_event (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_evt,
  input  logic clear,
  input  logic rd_ctrl,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (zero_evt)               flag <= 1'b1;
      else if (clear || rd_ctrl)  flag <= 1'b0;
      irq <= zero_evt && irq_en;
    end
  end

endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
  import tdt_pkg::*;
#(
  parameter int unsigned CNT_W = 24,
  parameter bit CAL_NOREF = 1'b0,
  parameter bit CAL_SKEW  = 1'b0,
  parameter logic [23:0] CAL_TENMS = 24'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_widx,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tick_irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] count_q;
  logic             flag_q;
  logic             cur_clear;
  logic             rd_ctrl;
  logic             tick_en;
  logic             zero_evt;
  logic             reload_evt;

  tdt_regs #(
    .CNT_W(CNT_W), .CAL_NOREF(CAL_NOREF), .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_widx(bus_widx), .bus_wdata(bus_wdata),
    .count(count_q), .flag(flag_q),
    .ctrl(ctrl_q), .reload(reload_q),
    .wr_current(cur_clear), .rd_ctrl(rd_ctrl), .bus_rdata(bus_rdata)
  );

  tdt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .run(ctrl_q.run), .src_core(ctrl_q.src_core), .ref_tick(ref_tick),
    .reload(reload_q), .clear(cur_clear),
    .count(count_q), .tick(tick_en), .zero_evt(zero_evt), .reload_evt(reload_evt)
  );

  tdt_event evt_i (
    .clk(clk), .rst_n(rst_n),
    .zero_evt(zero_evt), .clear(cur_clear), .rd_ctrl(rd_ctrl), .irq_en(ctrl_q.irq_en),
    .flag(flag_q), .irq(tick_irq)
  );

endmodule

// File: rtl/tdt_checker.sv
module tdt_checker #(
  parameter int unsigned CNT_W = 24,
  parameter bit CAL_NOREF = 1'b0,
  parameter bit CAL_SKEW  = 1'b0,
  parameter logic [23:0] CAL_TENMS = 24'h0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             zero_evt,
  input logic             reload_evt,
  input logic             cur_clear,
  input logic             rd_ctrl,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             flag,
  input logic             irq,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [1:0]       bus_widx,
  input logic [31:0]      bus_rdata
);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cur_clear) |=> (count == $past(count)));

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (count == $past(reload)));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (flag && count == '0));

  a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !zero_evt) |=> !flag);

  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && count == '0));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cur_clear |=> (count == '0 && !flag && !irq));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && reload == '0) |=> (count == '0 && !irq));

  a_r2_ctrl_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_widx == 2'd0) |->
      (bus_rdata[31:17] == '0 && bus_rdata[15:3] == '0));

  a_r10_calib: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_widx == 2'd3) |->
      (bus_rdata == {CAL_NOREF, CAL_SKEW, 6'b0, CAL_TENMS}));

endmodule

bind tick_down_timer tdt_checker #(
  .CNT_W(CNT_W), .CAL_NOREF(CAL_NOREF), .CAL_SKEW(CAL_SKEW), .CAL_TENMS(CAL_TENMS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_en), .zero_evt(zero_evt),
  .reload_evt(reload_evt), .cur_clear(cur_clear), .rd_ctrl(rd_ctrl),
  .count(count_q), .reload(reload_q), .flag(flag_q), .irq(tick_irq),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_widx(bus_widx), .bus_rdata(bus_rdata)
);

// File: tb/tick_down_timer_tb_top.sv
`timescale 1ns/1ps
module tick_down_timer_tb_top;

  localparam int unsigned CNT_W = 8;
  localparam logic [23:0] TENMS = 24'h001F40;
  localparam logic [31:0] CAL_EXP = {1'b1, 1'b1, 6'b0, TENMS};
  localparam logic [31:0] RLD_MASK = 32'((64'd1 << CNT_W) - 64'd1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_widx = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tick_down_timer #(
    .CNT_W(CNT_W), .CAL_NOREF(1'b1), .CAL_SKEW(1'b1), .CAL_TENMS(TENMS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_widx(bus_widx), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_irq(tick_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = idx; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = idx;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic hold_read(input logic [1:0] idx);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = idx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin
    logic [31:0] rd, rd2;
    int errs;
    int expv;
    bit irq_exp;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(2'd0, rd); check("R1 ctrl reset", rd, 32'h0);
    bus_read(2'd1, rd); check("R1 reload reset", rd, 32'h0);
    bus_read(2'd2, rd); check("R1 count reset", rd, 32'h0);
    check("R1 irq low", {31'b0, tick_irq}, 32'h0);

    // R2 control layout, zero bits and flag write ignored
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, rd); check("R2 ctrl writable bits", rd, 32'h0000_0007);
    bus_write(2'd0, 32'h0001_0000);
    bus_read(2'd0, rd); check("R2 flag write ignored", rd, 32'h0);

    // R4 reload width
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, rd); check("R4 reload truncation", rd, RLD_MASK);

    // R10 calibration word and write ignored
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, rd); check("R10 calib word", rd, CAL_EXP);

    // R4 R6 R11 period sweep on core clock, plus R5 and R3 after each run
    for (int r = 1; r <= 12; r++) begin
      bus_write(2'd0, 32'h0);
      bus_write(2'd2, 32'h0);
      bus_write(2'd1, 32'(r));
      bus_write(2'd0, 32'h7);
      hold_read(2'd2);
      errs = 0;
      for (int k = 1; k <= 2 * r + 2; k++) begin
        @(negedge clk);
        #1;
        expv = r - ((k - 1) % (r + 1));
        irq_exp = (k == r + 1) || (k == 2 * r + 2);
        if (bus_rdata !== 32'(expv) || tick_irq !== irq_exp) errs++;
      end
      check($sformatf("R4 R6 R11 period reload=%0d mismatches", r), 32'(errs), 32'h0);
      bus_sel = 1'b0;
      bus_write(2'd0, 32'h0);
      bus_read(2'd0, rd); check("R5 flag after wrap", rd, 32'h0001_0000);
      bus_read(2'd0, rd); check("R5 flag cleared by read", rd, 32'h0);
      bus_read(2'd2, rd);
      repeat (5) @(negedge clk);
      bus_read(2'd2, rd2); check("R3 count holds when stopped", rd2, rd);
    end

    // R5 set wins over simultaneous control read
    bus_write(2'd2, 32'h0);
    bus_write(2'd1, 32'd2);
    bus_write(2'd0, 32'h7);
    hold_read(2'd0);
    repeat (3) @(negedge clk);
    #1 check("R5 set beats read", bus_rdata, 32'h0001_0007);
    check("R6 irq on zero", {31'b0, tick_irq}, 32'h1);
    @(negedge clk);
    #1 check("R5 cleared by next read", bus_rdata, 32'h0000_0007);
    check("R6 irq one cycle", {31'b0, tick_irq}, 32'h0);
    bus_sel = 1'b0;

    // R6 interrupt disabled
    bus_write(2'd0, 32'h0);
    bus_write(2'd2, 32'h0);
    bus_write(2'd1, 32'd3);
    bus_write(2'd0, 32'h5);
    errs = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      #1 if (tick_irq !== 1'b0) errs++;
    end
    check("R6 no irq when disabled", 32'(errs), 32'h0);
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, rd); check("R6 flag still set", rd, 32'h0001_0000);

    // R7 count-clear write on the zero-step edge
    bus_write(2'd2, 32'h0);
    bus_write(2'd1, 32'd3);
    bus_write(2'd0, 32'h7);
    hold_read(2'd2);
    repeat (3) @(negedge clk);
    #1 check("R11 live count", bus_rdata, 32'h1);
    bus_wr = 1'b1; bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 check("R7 count cleared", bus_rdata, 32'h0);
    check("R7 no irq from clear", {31'b0, tick_irq}, 32'h0);
    @(negedge clk);
    #1 check("R7 reload after clear", bus_rdata, 32'h3);
    check("R7 still no irq", {31'b0, tick_irq}, 32'h0);
    bus_sel = 1'b0;
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, rd); check("R7 no flag from clear", rd, 32'h0);

    // R7 flag cleared by count write
    bus_write(2'd2, 32'h0);
    bus_write(2'd1, 32'd1);
    bus_write(2'd0, 32'h5);
    repeat (6) @(negedge clk);
    bus_write(2'd0, 32'h0);
    bus_write(2'd2, 32'h0);
    bus_read(2'd0, rd); check("R7 flag cleared by count write", rd, 32'h0);

    // R8 reference tick gating
    bus_write(2'd2, 32'h0);
    bus_write(2'd1, 32'd4);
    bus_write(2'd0, 32'h3);
    hold_read(2'd2);
    expv = 0;
    errs = 0;
    for (int k = 0; k < 40; k++) begin
      ref_tick = (k % 3 == 0);
      irq_exp = ref_tick && (expv == 1);
      if (ref_tick) expv = (expv == 0) ? 4 : expv - 1;
      @(negedge clk);
      #1 if (bus_rdata !== 32'(expv) || tick_irq !== irq_exp) errs++;
    end
    ref_tick = 1'b0;
    check("R8 reference tick gating mismatches", 32'(errs), 32'h0);
    bus_sel = 1'b0;

    // R9 zero reload stays idle
    bus_write(2'd0, 32'h0);
    bus_write(2'd2, 32'h0);
    bus_write(2'd1, 32'h0);
    bus_write(2'd0, 32'h7);
    hold_read(2'd2);
    errs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      #1 if (bus_rdata !== 32'h0 || tick_irq !== 1'b0) errs++;
    end
    check("R9 idle at zero mismatches", 32'(errs), 32'h0);
    bus_sel = 1'b0;
    bus_write(2'd0, 32'h0);
    bus_read(2'd0, rd); check("R9 no flag", rd, 32'h0);

    finish_test();
  end

endmodule